// File: doc/BRIEF.md
# Serial-Bus Memory Page-Write Slave

This block is the write side of a two-wire serial-bus slave that fronts a 256-byte memory array. It watches oversampled clock and data lines, recognises the start and stop conditions, and takes in three kinds of byte: its own device address with the direction bit, a word address, and any number of data bytes. It acknowledges each byte it accepts by pulling the open-drain data line low for the ninth clock.

Data bytes are not written to the array as they arrive. They land in a 16-entry page buffer, indexed by the low four bits of an address pointer that wraps inside the page. The whole page goes into the array in one timed internal write cycle that begins at the stop condition. While that cycle runs, a busy output is high and the slave answers no address at all. A master can therefore poll: it issues a start and a write-mode address until the slave acknowledges.

Two guards can stop a write. A hardware protect input covers the whole array. A software lock, once set, stays set until reset and covers the lower half of the array. A protected write, or a transaction that carries no data byte, is still acknowledged byte by byte. It starts no write cycle, and the slave is ready again at once. A combinational peek port shows array contents for inspection.

Top module: `eeprom_page_writer`

## Requirements
- R1: The slave acknowledges a first byte after START only when it equals {4'b1010, strap[2:0], 1'b0}, with the direction bit as bit 0 and 0 meaning write. Any other value, including the direction bit set to 1, gets no acknowledge, and every byte after it is ignored until the next START.
- R2: The byte after an accepted device address is loaded into the address pointer and acknowledged. Every later data byte is acknowledged and buffered for the location the pointer selects.
- R3: After each data byte only pointer bits [3:0] increment, wrapping from 0xF to 0x0, and bits [7:4] hold. More than 16 data bytes overwrite the earlier buffered bytes in the same page.
- R4: The array changes only after STOP. A STOP that ends a data phase starts one write cycle, during which busy is high for exactly WR_CYCLES clocks. Every buffered byte reaches the array together, at the edge where busy falls.
- R5: While busy is high, the slave acknowledges nothing, not even its own write address.
- R6: When hwProtect is high at STOP, the bytes are still acknowledged but no write cycle starts, the array is unchanged and busy stays low.
- R7: A pulse on swLockSet sets swLocked, which stays high until reset. While it is high, a page at 0x00 to 0x7F is not written and starts no cycle. A page at 0x80 to 0xFF is written normally.
- R8: A transaction that stops after the word address, with no data byte, starts no write cycle, and the next address is acknowledged at once.
- R9: The acknowledge drive (sdaOe high) starts and ends only while the synchronised clock line is low.
- R10: After reset, busy, sdaOe and swLocked are low and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| strap | input | 3 | Low three bits of the device address |
| hwProtect | input | 1 | High blocks writes to the whole array |
| swLockSet | input | 1 | Pulse sets the sticky lower-half lock |
| peekAddr | input | 8 | Array address to inspect |
| sdaOe | output | 1 | High pulls the data line low (acknowledge) |
| busy | output | 1 | High during the internal write cycle |
| swLocked | output | 1 | State of the sticky lower-half lock |
| peekData | output | 8 | Array byte at peekAddr |

## Verification
On every cycle the assertions check four things. The acknowledge drive changes only while the clock line is low, and no acknowledge starts during a write cycle. The page bits of the pointer hold across a data byte, and the lock never clears. A stop that is protected or has no data leaves busy low. Only the bench scenarios can show that the right bytes reach the right locations, including the wrap overwrite inside a page. They also show that the write cycle lasts exactly its configured length, that polling is refused and then accepted, and that a wrong address or a read request is ignored to the end of its transaction.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WADDR, ST_DATA, ST_SKIP} epw_state_t;

  typedef struct packed {
    logic       openPage;
    logic       loadPtr;
    logic       pushByte;
    logic       commit;
    logic [7:0] byteVal;
  } epw_strobe_t;
endpackage

// File: rtl/epw_ctrl.sv
module epw_ctrl
  import epw_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strap,
  input  logic        busy,
  output logic        sdaOe,
  output epw_strobe_t stb
);
  logic [1:0] sclSh, sdaSh;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;
  logic       startSeen, stopSeen, sclRise, sclFall;
  epw_state_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       ackPhase, byteDone, giveAck, devMatch, collecting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= 2'b11; sdaSh <= 2'b11;
      sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSh <= {sclSh[0], sclIn};
      sdaSh <= {sdaSh[0], sdaIn};
      sclPrev <= sclSh[1];
      sdaPrev <= sdaSh[1];
    end
  end

  assign sclNow    = sclSh[1];
  assign sdaNow    = sdaSh[1];
  assign startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopSeen  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign sclRise   = sclNow && !sclPrev;
  assign sclFall   = !sclNow && sclPrev;
  assign collecting = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_DATA);
  assign byteDone  = sclFall && !ackPhase && (bitCnt == 4'd8) && collecting;
  assign devMatch  = (shiftReg == {DEV_PREFIX, strap, 1'b0});

  always_comb begin
    case (state)
      ST_DEV:   giveAck = devMatch && !busy;
      ST_WADDR: giveAck = 1'b1;
      ST_DATA:  giveAck = 1'b1;
      default:  giveAck = 1'b0;
    endcase
  end

  always_comb begin
    stb.openPage = byteDone && (state == ST_DEV) && giveAck;
    stb.loadPtr  = byteDone && (state == ST_WADDR);
    stb.pushByte = byteDone && (state == ST_DATA);
    stb.commit   = stopSeen && (state == ST_DATA);
    stb.byteVal  = shiftReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= 4'd0; shiftReg <= 8'd0;
      ackPhase <= 1'b0; sdaOe <= 1'b0;
    end else if (startSeen) begin
      state <= ST_DEV; bitCnt <= 4'd0; ackPhase <= 1'b0; sdaOe <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE; bitCnt <= 4'd0; ackPhase <= 1'b0; sdaOe <= 1'b0;
    end else begin
      if (sclRise && !ackPhase && collecting && (bitCnt < 4'd8)) begin
        shiftReg <= {shiftReg[6:0], sdaNow};
        bitCnt   <= bitCnt + 4'd1;
      end
      if (byteDone) begin
        if (giveAck) begin
          sdaOe <= 1'b1; ackPhase <= 1'b1;
        end else begin
          state <= ST_SKIP;
        end
      end else if (sclFall && ackPhase) begin
        sdaOe <= 1'b0; ackPhase <= 1'b0; bitCnt <= 4'd0;
        if (state == ST_DEV)        state <= ST_WADDR;
        else if (state == ST_WADDR) state <= ST_DATA;
      end
    end
  end

  // R9: acknowledge drive only changes while the clock line is low
  assert_ack_on_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclNow);
  assert_ack_off_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclNow);
  // R5: no acknowledge begins during a write cycle
  assert_silent_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !$rose(sdaOe));
endmodule

// File: rtl/epw_data.sv
module epw_data
  import epw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  epw_strobe_t       stb,
  input  logic              hwProtect,
  input  logic              swLockSet,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic              busy,
  output logic              swLocked,
  output logic [7:0]        peekData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageVal;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  busyCnt;
  logic              blocked, commitGo, writeNow;

  assign blocked  = hwProtect || (swLocked && !ptr[ADDR_W-1]);
  assign commitGo = stb.commit && (|pageVal) && !blocked && !busy;
  assign busy     = (busyCnt != '0);
  assign writeNow = (busyCnt == CNT_W'(1));
  assign peekData = mem[peekAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swLocked <= 1'b0;
    else if (swLockSet) swLocked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (commitGo) busyCnt <= CNT_W'(WR_CYCLES);
    else if (busy) busyCnt <= busyCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0; pageVal <= '0;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= 8'd0;
    end else begin
      if (stb.openPage) pageVal <= '0;
      if (stb.loadPtr) ptr <= stb.byteVal[ADDR_W-1:0];
      if (stb.pushByte) begin
        pageBuf[ptr[PAGE_W-1:0]] <= stb.byteVal;
        pageVal[ptr[PAGE_W-1:0]] <= 1'b1;
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'd0;
    end else if (writeNow) begin
      for (int i = 0; i < PAGE; i++)
        if (pageVal[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  // R3: the page bits of the pointer hold across a data byte
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushByte |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  // R6: a hardware-protected stop starts no cycle
  assert_hw_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && hwProtect && !busy) |=> !busy);
  // R7: the lock never clears once set
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    swLocked |=> swLocked);
  // R8: a stop with nothing buffered starts no cycle
  assert_empty_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && (pageVal == '0) && !busy) |=> !busy);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       hwProtect,
  input  logic       swLockSet,
  input  logic [7:0] peekAddr,
  output logic       sdaOe,
  output logic       busy,
  output logic       swLocked,
  output logic [7:0] peekData
);
  epw_strobe_t stb;

  epw_ctrl #(.DEV_PREFIX(4'b1010)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .busy(busy), .sdaOe(sdaOe), .stb(stb)
  );

  epw_data #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(WR_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .hwProtect(hwProtect),
    .swLockSet(swLockSet), .peekAddr(peekAddr), .busy(busy),
    .swLocked(swLocked), .peekData(peekData)
  );
endmodule

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
  localparam int WR = 300;
  localparam int Q  = 6;
  localparam logic [6:0] DEV = 7'h55;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaBus;
  logic [2:0] strap = 3'b101;
  logic hwProtect = 1'b0, swLockSet = 1'b0;
  logic [7:0] peekAddr = 8'd0;
  logic sdaOe, busy, swLocked;
  logic [7:0] peekData;

  int total = 0, bad = 0, busyRun = 0;
  int modelMem [256];
  bit modelLock = 0, done = 0;

  always #4 clk = ~clk;
  assign sdaBus = mSda & ~sdaOe;

  eeprom_page_writer #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strap(strap),
    .hwProtect(hwProtect), .swLockSet(swLockSet), .peekAddr(peekAddr),
    .sdaOe(sdaOe), .busy(busy), .swLocked(swLocked), .peekData(peekData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R4: every busy pulse lasts exactly WR clocks, watched each cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyRun++;
      else if (busyRun != 0) begin
        chk(busyRun == WR, "R4 busy length", busyRun, WR);
        busyRun = 0;
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    mSda = 1'b1; wq(); mScl = 1'b1; wq(); mSda = 1'b0; wq(); mScl = 1'b0; wq();
  endtask

  task automatic stopCond();
    mSda = 1'b0; wq(); mScl = 1'b1; wq(); mSda = 1'b1; wq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; wq(); mScl = 1'b1; wq(); wq(); mScl = 1'b0; wq();
    end
    mSda = 1'b1; wq(); mScl = 1'b1; wq();
    ack = !sdaBus;
    wq(); mScl = 1'b0; wq();
  endtask

  task automatic checkMem(input string req);
    int errs = 0, firstA = -1, firstV = 0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); peekAddr = a[7:0]; #1;
      if (int'(peekData) != modelMem[a]) begin
        errs++;
        if (firstA < 0) begin firstA = a; firstV = int'(peekData); end
      end
    end
    chk(errs == 0, req, firstV, (firstA < 0) ? 0 : modelMem[firstA]);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  // full write transaction with model update
  task automatic writeTxn(input logic [6:0] dev, input logic [7:0] addr,
                          input int data[$], input bit expDev, input string req);
    bit ack, prot;
    int pend [16];
    bit pv [16];
    logic [7:0] p;
    for (int i = 0; i < 16; i++) pv[i] = 0;
    startCond();
    sendByte({dev, 1'b0}, ack);
    chk(ack == expDev, {req, " device ack (R1)"}, ack, expDev);
    if (ack) begin
      sendByte(addr, ack);
      chk(ack, {req, " word addr ack (R2)"}, ack, 1);
      p = addr;
      foreach (data[k]) begin
        sendByte(data[k][7:0], ack);
        chk(ack, {req, " data ack (R2)"}, ack, 1);
        pend[p[3:0]] = data[k]; pv[p[3:0]] = 1;
        p = {p[7:4], p[3:0] + 4'd1};
      end
    end else begin
      foreach (data[k]) begin
        sendByte(data[k][7:0], ack);
        chk(!ack, {req, " ignored byte (R1)"}, ack, 0);
      end
    end
    stopCond();
    prot = hwProtect || (modelLock && !addr[7]);
    if (expDev && data.size() > 0 && !prot) begin
      for (int i = 0; i < 16; i++)
        if (pv[i]) modelMem[{addr[7:4], i[3:0]}] = pend[i];
      repeat (6) @(negedge clk);
      chk(busy, {req, " busy after stop (R4)"}, busy, 1);
      startCond();
      sendByte({DEV, 1'b0}, ack);
      chk(!ack, {req, " poll refused while busy (R5)"}, ack, 0);
      stopCond();
      waitIdle();
      repeat (2) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
      chk(!busy, {req, " no cycle"}, busy, 0);
      if (expDev) begin
        startCond();
        sendByte({DEV, 1'b0}, ack);
        chk(ack, {req, " ready at once (R8)"}, ack, 1);
        stopCond();
        repeat (6) @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    int d[$];
    for (int a = 0; a < 256; a++) modelMem[a] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy, "R10 busy", busy, 0);
    chk(!sdaOe, "R10 sdaOe", sdaOe, 0);
    chk(!swLocked, "R10 swLocked", swLocked, 0);
    checkMem("R10 array zero");

    // R2/R4 single byte
    d = '{8'hA5};
    writeTxn(DEV, 8'h35, d, 1, "R2 byte");
    checkMem("R4 single byte");

    // R3 wrap inside page, partial
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    writeTxn(DEV, 8'h4C, d, 1, "R3 wrap5");
    checkMem("R3 wrap to page start");

    // R3 overwrite after 16
    d.delete();
    for (int i = 0; i < 18; i++) d.push_back(8'h60 + i);
    writeTxn(DEV, 8'h90, d, 1, "R3 over16");
    checkMem("R3 overwrite");

    // R1 wrong strap and read bit
    d = '{8'h12, 8'h34};
    writeTxn(7'h51, 8'h00, d, 0, "R1 mismatch");
    startCond();
    sendByte({DEV, 1'b1}, ack);
    chk(!ack, "R1 read bit refused", ack, 0);
    stopCond();
    repeat (6) @(negedge clk);
    checkMem("R1 array untouched");

    // R8 address only
    d.delete();
    writeTxn(DEV, 8'h70, d, 1, "R8 addr only");
    checkMem("R8 array untouched");

    // R6 hardware protect
    hwProtect = 1'b1;
    d = '{8'hEE, 8'hDD};
    writeTxn(DEV, 8'hA0, d, 1, "R6 hw");
    hwProtect = 1'b0;
    checkMem("R6 array untouched");

    // R7 software lock
    @(negedge clk); swLockSet = 1'b1; @(negedge clk); swLockSet = 1'b0;
    modelLock = 1;
    repeat (3) @(negedge clk);
    chk(swLocked, "R7 lock set", swLocked, 1);
    d = '{8'h99};
    writeTxn(DEV, 8'h10, d, 1, "R7 low half");
    checkMem("R7 low half blocked");
    d = '{8'h77, 8'h88};
    writeTxn(DEV, 8'hC3, d, 1, "R7 high half");
    checkMem("R7 high half written");
    chk(swLocked, "R7 lock sticky", swLocked, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule